// File: doc/BRIEF.md
# Level-Interrupt to Message Request Aggregator

This block gathers up to 25 level-high interrupt lines from an Ethernet MAC subsystem and reduces them to a single message request toward a PCIe endpoint. Each line first passes through a two-flop synchronizer. A source takes part in message generation only when its bit in the enable register is set. The status register shows which enabled sources are asserted at present. Source positions are fixed. Bit 0 is low-power idle and bit 1 is power management. Bit 2 is the general MAC event. Bits 3..10 are the transmit channels and bits 11..18 are the receive channels. Bit 19 is the PCS, bit 20 the PHY and bit 21 the mailbox. Bit 24 is a pulse-style request. Bits 22 and 23 carry no source.

Only one message may be outstanding at a time. The request is raised while the sequencer is in `ST_IDLE` and sees any enabled synchronized source high (transition `ST_IDLE -> ST_REQ`). It is held until the endpoint acknowledges it (`ST_REQ -> ST_HELD`). The sequencer then stays in `ST_HELD` until software writes the clear bit. At that write, if any enabled source is still high, it re-enters `ST_REQ` at once (`ST_HELD -> ST_REQ`). This covers level sources that never deasserted. If no enabled source is high, it returns to `ST_IDLE` (`ST_HELD -> ST_IDLE`).

The register port is a single-cycle 32-bit interface. Reads are combinational on the address and writes take effect at the clock edge. The enable register is at 0x00, the clear register at 0x0C and the status register at 0x10.

Top module: `irq_msi_gather`

## Requirements
- R1: After reset the enable register reads 0, the status register reads 0 and `msi_req` is low.
- R2: A write to offset 0x00 loads bits 24..0 into the enable register. Reading 0x00 returns them, with bits 31..25 reading zero.
- R3: Offset 0x10 reads the bitwise AND of the synchronized sources and the enable register, with bits 31..25 zero. Writes to 0x10 change no register.
- R4: An interrupt input change shows in the status register after exactly two rising clock edges.
- R5: From `ST_IDLE`, `msi_req` rises one clock edge after an enabled synchronized source is high. For a fresh input this is the third edge after the input changes.
- R6: `msi_req` stays high until a cycle with `msi_ack` high. It is low after that edge.
- R7: After an acknowledge, no new request is raised, whatever the sources do, until the clear bit is written.
- R8: A write to 0x0C with bit 0 set ends the hold. If an enabled source is high at that edge, `msi_req` is high right after the same edge. Otherwise it stays low.
- R9: Offset 0x0C reads zero. A write to 0x0C with bit 0 clear has no effect.
- R10: Any offset other than 0x00, 0x0C and 0x10 reads zero, and writes to it change nothing.
- R11: A source whose enable bit is 0 never causes a request and never appears in status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 25 | Level-high interrupt sources, fixed bit positions |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Word-aligned byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| msi_req | output | 1 | Message request, held until acknowledged |
| msi_ack | input | 1 | One-cycle acknowledge from the endpoint |

## Verification
The checker watches every cycle for the following properties. The request holds until an acknowledge and drops after it. No request appears between an acknowledge and the next clear write. The clear, unmapped and upper status bits read as zero. Other behaviour can only be shown by the bench's scenarios, where a behavioural reference model is compared on every clock. This covers the two-edge synchronizer latency and the exact cycle a request rises after an enable or a clear. It also covers a clear with no source pending, a clear write with bit 0 low, and sources masked by their enable bits.

// File: rtl/irqmsi_pkg.sv
package irqmsi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_HELD = 2'd2
    } msi_state_e;
endpackage

// File: rtl/irqmsi_sync.sv
module irqmsi_sync #(
    parameter int WIDTH  = 25,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/irqmsi_regs.sv
module irqmsi_regs #(
    parameter int          NUM_SRC  = 25,
    parameter int          AW       = 8,
    parameter int          DW       = 32,
    parameter logic [7:0]  OFF_EN   = 8'h00,
    parameter logic [7:0]  OFF_CLR  = 8'h0C,
    parameter logic [7:0]  OFF_STAT = 8'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    input  logic [NUM_SRC-1:0] src_sync,
    output logic [DW-1:0]      rdata,
    output logic               clr_pulse,
    output logic               pending
);
    localparam int PAD = DW - NUM_SRC;

    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] masked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (wr_en && addr == AW'(OFF_EN)) begin
            enable_q <= wdata[NUM_SRC-1:0];
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_mask
            assign masked[g] = src_sync[g] & enable_q[g];
        end
    endgenerate

    assign pending   = |masked;
    assign clr_pulse = wr_en && (addr == AW'(OFF_CLR)) && wdata[0];

    always_comb begin
        rdata = '0;
        if (addr == AW'(OFF_EN)) begin
            rdata = {{PAD{1'b0}}, enable_q};
        end else if (addr == AW'(OFF_STAT)) begin
            rdata = {{PAD{1'b0}}, masked};
        end
    end
endmodule

// File: rtl/irqmsi_fsm.sv
module irqmsi_fsm
    import irqmsi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic clr,
    input  logic ack,
    output logic msi_req
);
    msi_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (pending) state_d = ST_REQ;
            ST_REQ:  if (ack)     state_d = ST_HELD;
            ST_HELD: if (clr)     state_d = pending ? ST_REQ : ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        msi_req = (state_q == ST_REQ);
    end
endmodule

// File: rtl/irq_msi_gather.sv
module irq_msi_gather #(
    parameter int          NUM_SRC     = 25,
    parameter int          SYNC_STAGES = 2,
    parameter int          AW          = 8,
    parameter int          DW          = 32,
    parameter logic [7:0]  OFF_EN      = 8'h00,
    parameter logic [7:0]  OFF_CLR     = 8'h0C,
    parameter logic [7:0]  OFF_STAT    = 8'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               reg_wr_en,
    input  logic [AW-1:0]      reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    output logic               msi_req,
    input  logic               msi_ack
);
    logic [NUM_SRC-1:0] src_sync;
    logic               clr_pulse;
    logic               pending;

    irqmsi_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_src),
        .q     (src_sync)
    );

    irqmsi_regs #(
        .NUM_SRC(NUM_SRC), .AW(AW), .DW(DW),
        .OFF_EN(OFF_EN), .OFF_CLR(OFF_CLR), .OFF_STAT(OFF_STAT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .src_sync  (src_sync),
        .rdata     (reg_rdata),
        .clr_pulse (clr_pulse),
        .pending   (pending)
    );

    irqmsi_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .clr     (clr_pulse),
        .ack     (msi_ack),
        .msi_req (msi_req)
    );
endmodule

// File: rtl/irq_msi_gather_checker.sv
module irq_msi_gather_checker #(
    parameter int          NUM_SRC  = 25,
    parameter int          AW       = 8,
    parameter int          DW       = 32,
    parameter logic [7:0]  OFF_EN   = 8'h00,
    parameter logic [7:0]  OFF_CLR  = 8'h0C,
    parameter logic [7:0]  OFF_STAT = 8'h10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr_en,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic          msi_req,
    input logic          msi_ack
);
    logic clr_seen;
    logic held;
    logic mapped;

    assign clr_seen = reg_wr_en && (reg_addr == AW'(OFF_CLR)) && reg_wdata[0];
    assign mapped   = (reg_addr == AW'(OFF_EN)) || (reg_addr == AW'(OFF_CLR)) ||
                      (reg_addr == AW'(OFF_STAT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                held <= 1'b0;
        else if (msi_req && msi_ack) held <= 1'b1;
        else if (clr_seen)         held <= 1'b0;
    end

    // R6
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_req && !msi_ack) |=> msi_req);
    // R6
    p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_req && msi_ack) |=> !msi_req);
    // R7
    p_no_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !clr_seen) |=> !msi_req);
    // R9
    p_clr_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == AW'(OFF_CLR)) |-> (reg_rdata == '0));
    // R10
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (reg_rdata == '0));
    // R3
    p_status_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == AW'(OFF_STAT)) |-> (reg_rdata[DW-1:NUM_SRC] == '0));
endmodule

bind irq_msi_gather irq_msi_gather_checker #(
    .NUM_SRC(NUM_SRC), .AW(AW), .DW(DW),
    .OFF_EN(OFF_EN), .OFF_CLR(OFF_CLR), .OFF_STAT(OFF_STAT)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .msi_req   (msi_req),
    .msi_ack   (msi_ack)
);

// File: tb/irq_msi_gather_bench.sv
module irq_msi_gather_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [24:0] irq_src = '0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msi_req;
    logic        msi_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_msi_gather u_irq_msi_gather (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .msi_req(msi_req), .msi_ack(msi_ack)
    );

    // behavioural reference model
    logic [24:0] hist[$];
    logic [24:0] m_sync = '0;
    logic [24:0] m_en = '0;
    int          m_state = 0;   // 0 idle, 1 requesting, 2 held

    function automatic logic [31:0] model_read(logic [7:0] a);
        if (a == 8'h00) return {7'd0, m_en};
        if (a == 8'h10) return {7'd0, m_sync & m_en};
        return 32'd0;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            m_sync = '0; m_en = '0; m_state = 0;
        end else begin
            bit act, clr;
            act = |(m_sync & m_en);
            clr = reg_wr_en && reg_addr == 8'h0C && reg_wdata[0];
            case (m_state)
                0: if (act) m_state = 1;
                1: if (msi_ack) m_state = 2;
                default: if (clr) m_state = act ? 1 : 0;
            endcase
            if (reg_wr_en && reg_addr == 8'h00) m_en = reg_wdata[24:0];
            hist.push_back(irq_src);
            if (hist.size() > 2) void'(hist.pop_front());
            m_sync = (hist.size() == 2) ? hist[0] : '0;
        end
        #2;
        if (rst_n && !done) begin
            check(msi_req == (m_state == 1), "R6 model msi_req", {31'd0, msi_req},
                  {31'd0, m_state == 1});
            check(reg_rdata == model_read(reg_addr), "R3 model read", reg_rdata,
                  model_read(reg_addr));
        end
    end

    task automatic cyc();
        @(posedge clk); #3;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic req_chk(bit exp, string tag);
        check(msi_req == exp, tag, {31'd0, msi_req}, {31'd0, exp});
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++; checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        done = 1;
        report();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        cyc();
        req_chk(0, "R1 msi_req after reset");
        rd_chk(8'h00, 32'h0, "R1 enable after reset");
        rd_chk(8'h10, 32'h0, "R1 status after reset");

        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk(8'h00, 32'h01FF_FFFF, "R2 enable readback");
        wr(8'h00, 32'h0);
        irq_src = 25'h8;
        repeat (4) cyc();
        req_chk(0, "R11 disabled source no request");
        rd_chk(8'h10, 32'h0, "R11 disabled source hidden in status");

        wr(8'h00, 32'h800);
        irq_src = 25'h808;
        reg_addr = 8'h10;
        cyc();
        rd_chk(8'h10, 32'h0, "R4 status after one edge");
        cyc();
        rd_chk(8'h10, 32'h800, "R4 status after two edges");
        req_chk(0, "R5 no request yet");
        cyc();
        req_chk(1, "R5 request raised");
        repeat (3) cyc();
        req_chk(1, "R6 request held without ack");
        msi_ack = 1'b1; cyc(); msi_ack = 1'b0;
        req_chk(0, "R6 request dropped after ack");

        wr(8'h00, 32'h80800);
        irq_src = 25'h80808;
        repeat (4) cyc();
        req_chk(0, "R7 no request while held");
        wr(8'h0C, 32'h2);
        req_chk(0, "R9 clear without bit0 ignored");
        rd_chk(8'h0C, 32'h0, "R9 clear register reads zero");
        cyc();
        req_chk(0, "R9 still held");
        wr(8'h0C, 32'h1);
        req_chk(1, "R8 clear with pending re-requests");
        msi_ack = 1'b1; cyc(); msi_ack = 1'b0;
        req_chk(0, "R6 second ack");

        irq_src = '0;
        repeat (3) cyc();
        wr(8'h0C, 32'h1);
        req_chk(0, "R8 clear with nothing pending");
        repeat (3) cyc();
        req_chk(0, "R8 idle stays quiet");
        irq_src = 25'h80000;
        cyc(); cyc();
        req_chk(0, "R5 not before third edge");
        cyc();
        req_chk(1, "R5 request from idle");
        msi_ack = 1'b1; cyc(); msi_ack = 1'b0;

        wr(8'h04, 32'hFFFF);
        rd_chk(8'h04, 32'h0, "R10 unmapped reads zero");
        rd_chk(8'h00, 32'h80800, "R10 unmapped write ignored");
        wr(8'h10, 32'h0);
        rd_chk(8'h00, 32'h80800, "R3 status write ignored");

        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom_range(0, 9);
            irq_src = (r < 3) ? 25'($urandom) : irq_src;
            msi_ack = ($urandom_range(0, 3) == 0);
            if (r == 9) begin
                reg_wr_en = 1'b1;
                case ($urandom_range(0, 3))
                    0: reg_addr = 8'h00;
                    1: reg_addr = 8'h0C;
                    2: reg_addr = 8'h10;
                    default: reg_addr = 8'h08;
                endcase
                reg_wdata = $urandom;
            end else begin
                reg_wr_en = 1'b0;
                reg_addr = ($urandom_range(0, 1) == 0) ? 8'h10 : 8'h00;
            end
            cyc();
        end
        reg_wr_en = 1'b0;
        msi_ack = 1'b0;
        cyc();
        done = 1;
        report();
        $finish;
    end
endmodule